// File: doc/BRIEF.md
# Cache Miss Holding Entry

This block is one tracking slot for an outstanding miss in a coherent cache. It holds the block's bookkeeping flags and two ordered lists of waiting requests. The primary list belongs to the transaction already sent toward memory. The deferred list holds requests that can only be served by a second transaction, issued after the first one completes. Each list item carries a request tag, an exclusive-access bit, a bit telling a processor-side request from a recorded snoop, and the cycle time at which the item was accepted.

After allocation, processor requests join one of the two lists. Before issue they always join the primary list. After issue they join the primary list only while that stays coherent with the request already in flight. Snoops that arrive while the miss is in service are recorded, ignored, or answered with a shared indication. They can also be answered with a memory-inhibit indication, which tells the snooper that this entry will supply ownership. When the primary list has drained, a promote command turns the deferred list into the new primary list in a single cycle and readies the entry for reissue. Items leave the head of the primary list one per cycle as responses are delivered.

At most one of allocate, promote, snoop and processor request is accepted in a cycle. A pop may happen in the same cycle as any of them.

Top module: `miss_track_entry`

## Requirements
- R1: With `busy` low, `alloc_ready` is high, and an `alloc_valid` pulse starts the entry. After it, `busy`=1, `tgt_count`=1 and `in_service`=0. `excl_need` equals `alloc_excl`, and the pending-invalidate and pending-shared flags are 0. `order_tag` equals `alloc_tag`, and the primary head holds that tag with `head_cpu_side`=1. While `busy` is high, `alloc_ready` is 0.
- R2: A processor request accepted while `in_service`=0 goes to the primary list, and if `cpu_excl`=1 it sets `excl_need`.
- R3: A processor request accepted while `in_service`=1 goes to the deferred list if any of these holds: the deferred list is non-empty, the pending-invalidate flag is set, or `excl_need`=0 and `cpu_excl`=1. Otherwise it goes to the primary list and leaves `excl_need` unchanged.
- R4: Every accepted processor request raises `tgt_count` by one, whichever list takes it. A deferred request with `cpu_excl`=1 sets a deferred-exclusive flag, and the next successful promote loads that flag into `excl_need`.
- R5: `snp_ready` is 0 while `in_service`=0. While the pending-invalidate flag is set, a snoop is accepted but has no effect: it adds no item, leaves `tgt_count` unchanged, and keeps `snp_inhibit` and `snp_shared` at 0.
- R6: An accepted snoop with `excl_need`=1 or `snp_excl`=1 is appended to the primary list with `head_cpu_side`=0, and `tgt_count` rises by one. `snp_inhibit` is 1 in that cycle exactly when `excl_need`=1. If `snp_excl`=1, the pending-invalidate flag is set.
- R7: An accepted snoop with `snp_excl`=0 against an entry with `excl_need`=0 adds no item. It drives `snp_shared`=1 in that cycle and sets the pending-shared flag.
- R8: `promote_ok` is 0, and nothing changes, when the deferred list is empty or the primary list is non-empty. Otherwise the deferred items become the primary list in order. The promote also loads `excl_need` from the deferred-exclusive flag, clears the pending flags and `in_service`, and sets `order_tag` to the first item's tag. `ready_time` becomes the later of `now_time` and that item's time.
- R9: `fill_shared` equals `fill_valid` while the pending-shared flag is set, and is 0 otherwise.
- R10: `dealloc` frees the entry only when both lists are empty and `tgt_count`=0. Otherwise `dealloc_err` is 1 in that cycle and the entry stays busy.
- R11: Each list holds `DEPTH` items. `cpu_ready` is 0 when the list the request would join is full. `snp_ready` is 0 when a snoop that would be recorded finds the primary list full.
- R12: `pop` removes the primary head and lowers `tgt_count` by one. Items leave in arrival order. A pop on an empty primary list has no effect.
- R13: Acceptance priority within a cycle is allocate, then promote, then snoop, then processor request. `cpu_ready` is 0 while `snp_valid` or `promote` is high, and `snp_ready` is 0 while `promote` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| now_time | input | TIME_W | Free-running cycle time |
| alloc_valid | input | 1 | Allocate with a first target |
| alloc_tag | input | TAG_W | Tag of the first target |
| alloc_excl | input | 1 | First target needs exclusive access |
| alloc_ready | output | 1 | Entry is free |
| issue | input | 1 | Miss transaction has been sent |
| cpu_valid | input | 1 | Processor request present |
| cpu_tag | input | TAG_W | Processor request tag |
| cpu_excl | input | 1 | Processor request needs exclusive access |
| cpu_ready | output | 1 | Processor request accepted |
| snp_valid | input | 1 | Snoop present |
| snp_tag | input | TAG_W | Snoop tag |
| snp_excl | input | 1 | Snoop needs exclusive access |
| snp_ready | output | 1 | Snoop accepted |
| snp_inhibit | output | 1 | Entry will supply ownership; memory must not answer |
| snp_shared | output | 1 | Snooper must treat its copy as shared |
| fill_valid | input | 1 | Fill response arriving |
| fill_shared | output | 1 | Mark the fill as shared |
| promote | input | 1 | Promote deferred list |
| promote_ok | output | 1 | Promote taken this cycle |
| pop | input | 1 | Remove the primary head |
| head_valid | output | 1 | Primary list non-empty |
| head_tag | output | TAG_W | Primary head tag |
| head_excl | output | 1 | Primary head needs exclusive access |
| head_cpu_side | output | 1 | Primary head is a processor request (0: snoop) |
| head_time | output | TIME_W | Primary head acceptance time |
| dealloc | input | 1 | Free the entry |
| dealloc_err | output | 1 | Illegal free attempt |
| busy | output | 1 | Entry allocated |
| in_service | output | 1 | Transaction in flight |
| excl_need | output | 1 | Transaction seeks exclusive ownership |
| pend_inval | output | 1 | Invalidation pending |
| pend_shared | output | 1 | Shared reply owed on fill |
| tgt_count | output | CNT_W | Total targets held |
| pri_full | output | 1 | Primary list full |
| pri_empty | output | 1 | Primary list empty |
| def_full | output | 1 | Deferred list full |
| def_empty | output | 1 | Deferred list empty |
| order_tag | output | TAG_W | Order stamp of the current transaction |
| ready_time | output | TIME_W | Earliest issue time of the current transaction |

## Verification
Several properties are checked on every cycle. The target count must equal the sum of both list levels. No snoop reply may appear outside service. The shared reply must only answer a read snoop against a read miss. An invalidation-pending request must land in the deferred list, and a promote must leave a non-empty primary list out of service. The scenarios alone show list order and item contents at the head as pops occur, the three routing conditions, the promoted exclusive flag and ready time, rejection on a full list, and the priority between a snoop and a processor request arriving together.

// File: rtl/miss_entry_pkg.sv
package miss_entry_pkg;
   // Outcome of a snoop against an in-service entry
   typedef enum logic [1:0] {
      SNP_IGNORE = 2'd0,
      SNP_RECORD = 2'd1,
      SNP_SHARE  = 2'd2
   } snp_act_e;
endpackage

// File: rtl/tgt_fifo.sv
module tgt_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [W-1:0]                 din,
   input  logic                         pop,
   output logic [W-1:0]                 head,
   output logic                         full,
   output logic                         empty,
   output logic [$clog2(DEPTH+1)-1:0]   level
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int LVL_W = $clog2(DEPTH+1);
   localparam bit POW2  = (DEPTH & (DEPTH-1)) == 0;

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] rd_ptr, wr_ptr, rd_nxt, wr_nxt;
   logic             do_push, do_pop;

   assign full    = (level == LVL_W'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign head    = mem[rd_ptr];

   generate
      if (POW2) begin : g_wrap_nat
         assign rd_nxt = rd_ptr + 1'b1;
         assign wr_nxt = wr_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/req_router.sv
module req_router (
   input  logic in_service,
   input  logic excl_need,
   input  logic pend_inv,
   input  logic def_empty,
   input  logic req_excl,
   output logic to_defer,
   output logic raise_excl,
   output logic raise_def_excl
);
   // After issue, a request waits for the next transaction if ordering or
   // ownership would otherwise be broken.
   assign to_defer       = in_service & (~def_empty | pend_inv | (~excl_need & req_excl));
   assign raise_excl     = ~in_service & req_excl;
   assign raise_def_excl = to_defer & req_excl;
endmodule

// File: rtl/snoop_resolver.sv
module snoop_resolver
   import miss_entry_pkg::*;
(
   input  logic     pend_inv,
   input  logic     excl_need,
   input  logic     snp_excl,
   output snp_act_e act,
   output logic     inhibit,
   output logic     set_inv
);
   always_comb begin
      if (pend_inv)                  act = SNP_IGNORE;
      else if (excl_need | snp_excl) act = SNP_RECORD;
      else                           act = SNP_SHARE;
   end
   assign inhibit = (act == SNP_RECORD) & excl_need;
   assign set_inv = (act == SNP_RECORD) & snp_excl;
endmodule

// File: rtl/miss_track_entry.sv
module miss_track_entry
   import miss_entry_pkg::*;
#(
   parameter int TAG_W  = 8,
   parameter int DEPTH  = 8,
   parameter int TIME_W = 16,
   localparam int CNT_W = $clog2(2*DEPTH+1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] now_time,
   input  logic              alloc_valid,
   input  logic [TAG_W-1:0]  alloc_tag,
   input  logic              alloc_excl,
   output logic              alloc_ready,
   input  logic              issue,
   input  logic              cpu_valid,
   input  logic [TAG_W-1:0]  cpu_tag,
   input  logic              cpu_excl,
   output logic              cpu_ready,
   input  logic              snp_valid,
   input  logic [TAG_W-1:0]  snp_tag,
   input  logic              snp_excl,
   output logic              snp_ready,
   output logic              snp_inhibit,
   output logic              snp_shared,
   input  logic              fill_valid,
   output logic              fill_shared,
   input  logic              promote,
   output logic              promote_ok,
   input  logic              pop,
   output logic              head_valid,
   output logic [TAG_W-1:0]  head_tag,
   output logic              head_excl,
   output logic              head_cpu_side,
   output logic [TIME_W-1:0] head_time,
   input  logic              dealloc,
   output logic              dealloc_err,
   output logic              busy,
   output logic              in_service,
   output logic              excl_need,
   output logic              pend_inval,
   output logic              pend_shared,
   output logic [CNT_W-1:0]  tgt_count,
   output logic              pri_full,
   output logic              pri_empty,
   output logic              def_full,
   output logic              def_empty,
   output logic [TAG_W-1:0]  order_tag,
   output logic [TIME_W-1:0] ready_time
);
   localparam int LVL_W  = $clog2(DEPTH+1);
   localparam int ITEM_W = TAG_W + 2 + TIME_W;

   generate
      if (DEPTH < 2)  begin : g_bad_depth $error("DEPTH must be at least 2");  end
      if (TAG_W < 1)  begin : g_bad_tag   $error("TAG_W must be at least 1");  end
      if (TIME_W < 2) begin : g_bad_time  $error("TIME_W must be at least 2"); end
   endgenerate

   typedef struct packed {
      logic [TAG_W-1:0]  tag;
      logic              excl;
      logic              cpu_side;
      logic [TIME_W-1:0] stamp;
   } item_t;

   // role selects which physical list currently acts as the primary list
   logic        role, def_excl;
   item_t       phys_head [2];
   logic        phys_full [2], phys_empty [2], phys_push [2], phys_pop [2];
   logic [LVL_W-1:0] phys_lvl [2];
   logic [ITEM_W-1:0] phys_din [2];
   logic [LVL_W-1:0] lvl_pri, lvl_def;
   item_t       pri_head, def_head, pri_item, def_item;

   logic     to_defer, raise_excl, raise_def_excl;
   snp_act_e snp_act;
   logic     snp_inh_raw, snp_set_inv;
   logic     alloc_fire, promote_fire, snp_fire, cpu_fire, pop_fire, dealloc_fire;
   logic     pri_push, def_push, free_legal;

   assign pri_head   = phys_head[role];
   assign def_head   = phys_head[~role];
   assign pri_full   = phys_full[role];
   assign pri_empty  = phys_empty[role];
   assign def_full   = phys_full[~role];
   assign def_empty  = phys_empty[~role];
   assign lvl_pri    = phys_lvl[role];
   assign lvl_def    = phys_lvl[~role];

   req_router u_router (
      .in_service(in_service), .excl_need(excl_need), .pend_inv(pend_inval),
      .def_empty(def_empty), .req_excl(cpu_excl), .to_defer(to_defer),
      .raise_excl(raise_excl), .raise_def_excl(raise_def_excl));

   snoop_resolver u_snoop (
      .pend_inv(pend_inval), .excl_need(excl_need), .snp_excl(snp_excl),
      .act(snp_act), .inhibit(snp_inh_raw), .set_inv(snp_set_inv));

   // acceptance, in priority order: allocate, promote, snoop, processor
   assign alloc_ready  = ~busy;
   assign alloc_fire   = alloc_valid & ~busy;
   assign promote_fire = promote & busy & ~def_empty & pri_empty;
   assign promote_ok   = promote_fire;
   assign snp_ready    = busy & in_service & ~promote &
                         ~((snp_act == SNP_RECORD) & pri_full);
   assign snp_fire     = snp_valid & snp_ready;
   assign cpu_ready    = busy & ~promote & ~snp_valid & (to_defer ? ~def_full : ~pri_full);
   assign cpu_fire     = cpu_valid & cpu_ready;
   assign pop_fire     = pop & busy & ~pri_empty;

   assign snp_inhibit  = snp_fire & snp_inh_raw;
   assign snp_shared   = snp_fire & (snp_act == SNP_SHARE);
   assign fill_shared  = fill_valid & busy & pend_shared;

   assign free_legal   = pri_empty & def_empty & (tgt_count == '0);
   assign dealloc_err  = dealloc & ~free_legal;
   assign dealloc_fire = dealloc & busy & free_legal;

   assign pri_push = alloc_fire | (cpu_fire & ~to_defer) | (snp_fire & (snp_act == SNP_RECORD));
   assign def_push = cpu_fire & to_defer;

   always_comb begin
      if (alloc_fire)    pri_item = '{tag: alloc_tag, excl: alloc_excl, cpu_side: 1'b1, stamp: now_time};
      else if (snp_fire) pri_item = '{tag: snp_tag,   excl: snp_excl,   cpu_side: 1'b0, stamp: now_time};
      else               pri_item = '{tag: cpu_tag,   excl: cpu_excl,   cpu_side: 1'b1, stamp: now_time};
   end
   assign def_item = '{tag: cpu_tag, excl: cpu_excl, cpu_side: 1'b1, stamp: now_time};

   for (genvar k = 0; k < 2; k++) begin : g_list
      logic is_pri;
      assign is_pri       = (k == 1) ? role : ~role;
      assign phys_push[k] = is_pri ? pri_push : def_push;
      assign phys_din[k]  = is_pri ? pri_item : def_item;
      assign phys_pop[k]  = is_pri & pop_fire;
      tgt_fifo #(.W(ITEM_W), .DEPTH(DEPTH)) u_fifo (
         .clk(clk), .rst_n(rst_n), .push(phys_push[k]), .din(phys_din[k]),
         .pop(phys_pop[k]), .head(phys_head[k]), .full(phys_full[k]),
         .empty(phys_empty[k]), .level(phys_lvl[k]));
   end

   assign head_valid    = busy & ~pri_empty;
   assign head_tag      = pri_head.tag;
   assign head_excl     = pri_head.excl;
   assign head_cpu_side = pri_head.cpu_side;
   assign head_time     = pri_head.stamp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy        <= 1'b0;
         in_service  <= 1'b0;
         excl_need   <= 1'b0;
         def_excl    <= 1'b0;
         pend_inval  <= 1'b0;
         pend_shared <= 1'b0;
         role        <= 1'b0;
         tgt_count   <= '0;
         order_tag   <= '0;
         ready_time  <= '0;
      end else begin
         tgt_count <= tgt_count + CNT_W'(pri_push) + CNT_W'(def_push) - CNT_W'(pop_fire);
         if (alloc_fire) begin
            busy        <= 1'b1;
            in_service  <= 1'b0;
            excl_need   <= alloc_excl;
            def_excl    <= 1'b0;
            pend_inval  <= 1'b0;
            pend_shared <= 1'b0;
            order_tag   <= alloc_tag;
            ready_time  <= now_time;
         end else if (dealloc_fire) begin
            busy       <= 1'b0;
            in_service <= 1'b0;
         end else begin
            if (promote_fire) begin
               role        <= ~role;
               excl_need   <= def_excl;
               def_excl    <= 1'b0;
               pend_inval  <= 1'b0;
               pend_shared <= 1'b0;
               in_service  <= 1'b0;
               order_tag   <= def_head.tag;
               ready_time  <= (now_time > def_head.stamp) ? now_time : def_head.stamp;
            end else if (issue & busy) begin
               in_service <= 1'b1;
            end
            if (snp_fire & snp_set_inv)               pend_inval  <= 1'b1;
            if (snp_fire & (snp_act == SNP_SHARE))    pend_shared <= 1'b1;
            if (cpu_fire & raise_excl)                excl_need   <= 1'b1;
            if (cpu_fire & raise_def_excl)            def_excl    <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/miss_track_entry_chk.sv
module miss_track_entry_chk #(
   parameter int DEPTH = 8,
   localparam int CNT_W = $clog2(2*DEPTH+1),
   localparam int LVL_W = $clog2(DEPTH+1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             alloc_valid,
   input logic             alloc_ready,
   input logic             cpu_valid,
   input logic             cpu_ready,
   input logic             snp_excl,
   input logic             snp_inhibit,
   input logic             snp_shared,
   input logic             promote_ok,
   input logic             busy,
   input logic             in_service,
   input logic             excl_need,
   input logic             pend_inval,
   input logic [CNT_W-1:0] tgt_count,
   input logic             pri_full,
   input logic             pri_empty,
   input logic             def_full,
   input logic             def_empty,
   input logic [LVL_W-1:0] lvl_pri,
   input logic [LVL_W-1:0] lvl_def
);
   // R4 / R12: the register count tracks both list levels
   always @(posedge clk) begin
      if (rst_n) begin
         a_r4_count_tracks_lists: assert (tgt_count == CNT_W'(lvl_pri) + CNT_W'(lvl_def))
            else $error("target count differs from list levels");
      end
   end

   a_r1_alloc_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && alloc_ready) |=> (busy && tgt_count == CNT_W'(1) && !in_service));

   a_r3_inval_defers: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && cpu_ready && in_service && pend_inval) |=> !def_empty);

   a_r5_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_service |-> (!snp_inhibit && !snp_shared));

   a_r7_shared_read_only: assert property (@(posedge clk) disable iff (!rst_n)
      snp_shared |-> (!snp_excl && !excl_need));

   a_r8_promote_result: assert property (@(posedge clk) disable iff (!rst_n)
      promote_ok |=> (!pri_empty && !in_service));

   a_r11_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_full && def_full) |-> !cpu_ready);
endmodule

bind miss_track_entry miss_track_entry_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
   .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .snp_excl(snp_excl),
   .snp_inhibit(snp_inhibit), .snp_shared(snp_shared), .promote_ok(promote_ok),
   .busy(busy), .in_service(in_service), .excl_need(excl_need),
   .pend_inval(pend_inval), .tgt_count(tgt_count), .pri_full(pri_full),
   .pri_empty(pri_empty), .def_full(def_full), .def_empty(def_empty),
   .lvl_pri(lvl_pri), .lvl_def(lvl_def));

// File: tb/miss_track_entry_tb_top.sv
`timescale 1ns/1ps
module miss_track_entry_tb_top;
   localparam int TAG_W = 8, DEPTH = 8, TIME_W = 16;
   localparam int CNT_W = $clog2(2*DEPTH+1);

   logic clk = 1'b0;
   always #2 clk = ~clk;
   logic rst_n = 1'b0;
   logic [TIME_W-1:0] tick = '0;
   always @(posedge clk) tick <= tick + 1'b1;

   logic alloc_valid = 0, alloc_excl = 0, issue = 0, cpu_valid = 0, cpu_excl = 0;
   logic snp_valid = 0, snp_excl = 0, fill_valid = 0, promote = 0, pop = 0, dealloc = 0;
   logic [TAG_W-1:0] alloc_tag = '0, cpu_tag = '0, snp_tag = '0;
   logic alloc_ready, cpu_ready, snp_ready, snp_inhibit, snp_shared, fill_shared, promote_ok;
   logic head_valid, head_excl, head_cpu_side, dealloc_err, busy, in_service, excl_need;
   logic pend_inval, pend_shared, pri_full, pri_empty, def_full, def_empty;
   logic [TAG_W-1:0] head_tag, order_tag;
   logic [TIME_W-1:0] head_time, ready_time;
   logic [CNT_W-1:0] tgt_count;

   miss_track_entry #(.TAG_W(TAG_W), .DEPTH(DEPTH), .TIME_W(TIME_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .now_time(tick),
      .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .alloc_excl(alloc_excl), .alloc_ready(alloc_ready),
      .issue(issue), .cpu_valid(cpu_valid), .cpu_tag(cpu_tag), .cpu_excl(cpu_excl), .cpu_ready(cpu_ready),
      .snp_valid(snp_valid), .snp_tag(snp_tag), .snp_excl(snp_excl), .snp_ready(snp_ready),
      .snp_inhibit(snp_inhibit), .snp_shared(snp_shared), .fill_valid(fill_valid), .fill_shared(fill_shared),
      .promote(promote), .promote_ok(promote_ok), .pop(pop), .head_valid(head_valid),
      .head_tag(head_tag), .head_excl(head_excl), .head_cpu_side(head_cpu_side), .head_time(head_time),
      .dealloc(dealloc), .dealloc_err(dealloc_err), .busy(busy), .in_service(in_service),
      .excl_need(excl_need), .pend_inval(pend_inval), .pend_shared(pend_shared), .tgt_count(tgt_count),
      .pri_full(pri_full), .pri_empty(pri_empty), .def_full(def_full), .def_empty(def_empty),
      .order_tag(order_tag), .ready_time(ready_time));

   typedef struct packed {
      logic [TAG_W-1:0]  tag;
      logic              excl;
      logic              cpu;
      logic [TIME_W-1:0] stamp;
   } exp_t;

   exp_t pri_q[$], def_q[$];
   exp_t mon_e;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // scoreboard monitor: every delivered head must match the oldest expected item
   always @(negedge clk) begin
      if (rst_n && pop && head_valid) begin
         if (pri_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R12 pop: actual tag %0h expected no item", head_tag);
         end else begin
            mon_e = pri_q.pop_front();
            check("R12", "head tag",  32'(head_tag),      32'(mon_e.tag));
            check("R12", "head excl", 32'(head_excl),     32'(mon_e.excl));
            check("R6",  "head side", 32'(head_cpu_side), 32'(mon_e.cpu));
            check("R12", "head time", 32'(head_time),     32'(mon_e.stamp));
         end
      end
   end

   task automatic settle();
      @(negedge clk);
   endtask

   task automatic do_alloc(input logic [TAG_W-1:0] t, input logic x);
      @(posedge clk); #1; alloc_valid = 1; alloc_tag = t; alloc_excl = x;
      @(negedge clk);
      check("R1", "alloc_ready", 32'(alloc_ready), 1);
      pri_q.push_back('{tag: t, excl: x, cpu: 1'b1, stamp: tick});
      @(posedge clk); #1; alloc_valid = 0;
   endtask

   task automatic do_cpu(input logic [TAG_W-1:0] t, input logic x, input logic exp_rdy,
                         input logic to_def, input string req);
      @(posedge clk); #1; cpu_valid = 1; cpu_tag = t; cpu_excl = x;
      @(negedge clk);
      check(req, "cpu_ready", 32'(cpu_ready), 32'(exp_rdy));
      if (exp_rdy) begin
         if (to_def) def_q.push_back('{tag: t, excl: x, cpu: 1'b1, stamp: tick});
         else        pri_q.push_back('{tag: t, excl: x, cpu: 1'b1, stamp: tick});
      end
      @(posedge clk); #1; cpu_valid = 0;
   endtask

   task automatic do_snp(input logic [TAG_W-1:0] t, input logic x, input logic exp_rdy,
                         input logic exp_inh, input logic exp_shr, input logic rec, input string req);
      @(posedge clk); #1; snp_valid = 1; snp_tag = t; snp_excl = x;
      @(negedge clk);
      check(req, "snp_ready",   32'(snp_ready),   32'(exp_rdy));
      check(req, "snp_inhibit", 32'(snp_inhibit), 32'(exp_inh));
      check(req, "snp_shared",  32'(snp_shared),  32'(exp_shr));
      if (exp_rdy && rec) pri_q.push_back('{tag: t, excl: x, cpu: 1'b0, stamp: tick});
      @(posedge clk); #1; snp_valid = 0;
   endtask

   task automatic do_issue();
      @(posedge clk); #1; issue = 1;
      @(posedge clk); #1; issue = 0;
   endtask

   task automatic do_pop(input int n);
      @(posedge clk); #1; pop = 1;
      repeat (n) @(posedge clk);
      #1; pop = 0;
   endtask

   task automatic do_promote(input logic exp_ok, output logic [TIME_W-1:0] t_at);
      @(posedge clk); #1; promote = 1;
      @(negedge clk);
      check("R8", "promote_ok", 32'(promote_ok), 32'(exp_ok));
      t_at = tick;
      if (exp_ok) begin
         pri_q = def_q;
         def_q.delete();
      end
      @(posedge clk); #1; promote = 0;
   endtask

   task automatic do_fill(input logic exp_shr);
      @(posedge clk); #1; fill_valid = 1;
      @(negedge clk);
      check("R9", "fill_shared", 32'(fill_shared), 32'(exp_shr));
      @(posedge clk); #1; fill_valid = 0;
   endtask

   task automatic do_dealloc(input logic exp_err);
      @(posedge clk); #1; dealloc = 1;
      @(negedge clk);
      check("R10", "dealloc_err", 32'(dealloc_err), 32'(exp_err));
      @(posedge clk); #1; dealloc = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [TIME_W-1:0] tp;
      repeat (3) @(posedge clk);
      #1; rst_n = 1;
      settle();
      check("R1", "reset busy",  32'(busy), 0);
      check("R1", "reset ready", 32'(alloc_ready), 1);
      check("R1", "reset count", 32'(tgt_count), 0);
      check("R1", "reset empty", 32'(pri_empty & def_empty), 1);

      // first miss: read allocation, exclusive request before issue
      do_alloc(8'h05, 1'b0); settle();
      check("R1", "busy", 32'(busy), 1);
      check("R1", "count", 32'(tgt_count), 1);
      check("R1", "excl_need", 32'(excl_need), 0);
      check("R1", "in_service", 32'(in_service), 0);
      check("R1", "order_tag", 32'(order_tag), 32'h05);
      check("R1", "alloc_ready busy", 32'(alloc_ready), 0);
      do_cpu(8'h06, 1'b1, 1'b1, 1'b0, "R2"); settle();
      check("R2", "excl_need raised", 32'(excl_need), 1);
      check("R4", "count", 32'(tgt_count), 2);
      do_issue(); settle();
      check("R3", "in_service", 32'(in_service), 1);
      do_cpu(8'h07, 1'b0, 1'b1, 1'b0, "R3"); settle();
      check("R3", "stays primary", 32'(def_empty), 1);
      check("R4", "count", 32'(tgt_count), 3);

      // snoops against an exclusive miss
      do_snp(8'h40, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R6"); settle();
      check("R6", "no inval on read", 32'(pend_inval), 0);
      check("R6", "count", 32'(tgt_count), 4);
      do_snp(8'h41, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R6"); settle();
      check("R6", "inval set", 32'(pend_inval), 1);
      do_snp(8'h42, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5"); settle();
      check("R5", "ignored count", 32'(tgt_count), 5);
      do_cpu(8'h08, 1'b0, 1'b1, 1'b1, "R3"); settle();
      check("R3", "deferred on inval", 32'(def_empty), 0);
      do_cpu(8'h09, 1'b1, 1'b1, 1'b1, "R4"); settle();
      check("R4", "count both lists", 32'(tgt_count), 7);

      do_promote(1'b0, tp); settle();
      check("R8", "no change", 32'(in_service), 1);
      do_fill(1'b0);
      do_dealloc(1'b1); settle();
      check("R10", "still busy", 32'(busy), 1);

      do_pop(6); settle();
      check("R12", "count after drain", 32'(tgt_count), 2);
      check("R12", "primary empty", 32'(pri_empty), 1);

      do_promote(1'b1, tp); settle();
      check("R4", "excl from deferred", 32'(excl_need), 1);
      check("R8", "inval cleared", 32'(pend_inval), 0);
      check("R8", "out of service", 32'(in_service), 0);
      check("R8", "order_tag", 32'(order_tag), 32'h08);
      check("R8", "ready_time", 32'(ready_time), 32'(tp));
      check("R8", "deferred empty", 32'(def_empty), 1);
      do_issue();
      do_pop(2); settle();
      check("R12", "count zero", 32'(tgt_count), 0);
      do_dealloc(1'b0); settle();
      check("R10", "freed", 32'(busy), 0);

      // second miss: read against read, then exclusive request after issue
      do_alloc(8'h20, 1'b0);
      do_issue();
      do_snp(8'h30, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R7"); settle();
      check("R7", "no record", 32'(tgt_count), 1);
      check("R7", "pending shared", 32'(pend_shared), 1);
      do_fill(1'b1);
      do_cpu(8'h21, 1'b1, 1'b1, 1'b1, "R3"); settle();
      check("R3", "excl deferred", 32'(def_empty), 0);
      check("R3", "excl_need kept", 32'(excl_need), 0);
      do_pop(1);
      do_promote(1'b1, tp); settle();
      check("R4", "excl loaded", 32'(excl_need), 1);
      check("R8", "shared cleared", 32'(pend_shared), 0);
      check("R8", "order_tag", 32'(order_tag), 32'h21);
      do_snp(8'h50, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5");

      // fill the primary list
      for (int i = 0; i < 7; i++) do_cpu(8'(8'h22 + i), 1'b0, 1'b1, 1'b0, "R2");
      settle();
      check("R11", "primary full", 32'(pri_full), 1);
      check("R11", "count", 32'(tgt_count), 8);
      do_cpu(8'h29, 1'b0, 1'b0, 1'b0, "R11");
      do_issue();
      do_snp(8'h60, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R11");
      do_pop(1);

      // snoop and processor request together: snoop wins
      @(posedge clk); #1;
      snp_valid = 1; snp_tag = 8'h61; snp_excl = 0;
      cpu_valid = 1; cpu_tag = 8'h62; cpu_excl = 0;
      @(negedge clk);
      check("R13", "snp_ready", 32'(snp_ready), 1);
      check("R13", "snp_inhibit", 32'(snp_inhibit), 1);
      check("R13", "cpu_ready", 32'(cpu_ready), 0);
      pri_q.push_back('{tag: 8'h61, excl: 1'b0, cpu: 1'b0, stamp: tick});
      @(posedge clk); #1; snp_valid = 0; cpu_valid = 0;
      settle();
      check("R13", "count", 32'(tgt_count), 8);

      do_pop(8); settle();
      check("R12", "final count", 32'(tgt_count), 0);
      check("R12", "scoreboard drained", 32'(pri_q.size()), 0);
      finish_run();
   end
endmodule